// File: doc/BRIEF.md
# Byte-Lane Memory Access Modifier

This block sits between a CPU datapath and a word-wide memory. It turns the next memory-reference instruction into a byte access. A prefix instruction arms one of two byte modes: the high lane or the low lane. That mode applies to the instruction that follows and to no other. When any non-arming instruction completes, the block returns to full-word access.

A byte read returns the chosen lane, zero-extended, in the low half of the operand. A byte store is a read-modify-write: the block reads the word, replaces only the chosen lane with the low byte of the operand, and writes the word back. While a byte mode is armed, the block drives a signal that keeps interrupts out, so the prefix and the instruction it modifies run as one atomic pair. Instructions that must always see whole words (jumps, subroutine calls, memory increment and decrement) raise a force input. This input makes their access full-word and clears the armed mode.

Top module: `byte_lane_ctrl`

## Requirements
- R1: After reset the mode is full-word, and `atomic_o`, `busy_o` and `mem_req_o` are low.
- R2: A pulse on `arm_hi_i` selects the high lane and a pulse on `arm_lo_i` selects the low lane, effective from the next cycle; `atomic_o` is high while either lane mode is armed.
- R3: When `instr_done_i` is high with `instr_is_arm_i` low, the mode returns to full-word on the next cycle, so `atomic_o` drops and later reads return whole words.
- R4: A completion flagged as arming (`instr_is_arm_i` high) leaves the armed mode unchanged, and a later arm pulse replaces the earlier mode.
- R5: A read in high-lane mode returns `{8'h00, word[15:8]}`.
- R6: A read in low-lane mode returns `{8'h00, word[7:0]}`.
- R7: A read issues one memory read and reports `op_done_o` with `op_rdata_o` valid in the cycle after the request; in full-word mode the whole word is returned.
- R8: A store in high-lane mode reads the word and then writes `{wdata[7:0], old[7:0]}`, with `busy_o` high during the write cycle.
- R9: A store in low-lane mode reads the word and then writes `{old[15:8], wdata[7:0]}`.
- R10: A full-word store writes the operand in the request cycle with `op_done_o` high in that cycle, and `busy_o` never rises.
- R11: With `force_normal_i` high during a request, the access is full-word whatever mode is armed, and the armed mode is cleared so `atomic_o` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_hi_i | input | 1 | Arm high-lane mode |
| arm_lo_i | input | 1 | Arm low-lane mode |
| instr_done_i | input | 1 | Instruction completion strobe |
| instr_is_arm_i | input | 1 | Completed instruction was an arming prefix |
| force_normal_i | input | 1 | Force full-word access and clear the mode |
| op_rd_req_i | input | 1 | Operand read request |
| op_wr_req_i | input | 1 | Operand write request |
| op_addr_i | input | 11 | Operand address |
| op_wdata_i | input | 16 | Operand write data |
| op_rdata_o | output | 16 | Operand read data (valid with done) |
| op_done_o | output | 1 | Operand access complete |
| busy_o | output | 1 | Access in progress beyond its request cycle |
| mem_req_o | output | 1 | Memory cycle request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 11 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, one cycle after a read |
| atomic_o | output | 1 | Blocks interrupt acceptance while a lane mode is armed |

## Verification
The bench uses words whose two bytes are clearly different. If the lanes were swapped, or the bytes were not zero-extended, the value read back would be plainly wrong. Stores are checked by reading the memory model afterwards. A plain write in place of the read-modify-write would wipe out the lane that should be kept. Further tests check that the mode lasts for one instruction only and that the force input wins: a sticky mode would cut the second read down to a byte, and a mode that ignores the force input would turn a jump's full-word fetch into a byte. The last test re-arms the block and checks that an arming completion does not clear the new mode.

// File: rtl/bl_pkg.sv
package bl_pkg;
  typedef enum logic [1:0] {
    LANE_FULL = 2'd0,
    LANE_HI   = 2'd1,
    LANE_LO   = 2'd2
  } lane_mode_e;
endpackage

// File: rtl/bl_mode_reg.sv
module bl_mode_reg
  import bl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_hi_i,
  input  logic       arm_lo_i,
  input  logic       instr_done_i,
  input  logic       instr_is_arm_i,
  input  logic       force_normal_i,
  output lane_mode_e mode_o
);
  lane_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           mode_q <= LANE_FULL;
    else if (arm_hi_i)                                     mode_q <= LANE_HI;
    else if (arm_lo_i)                                     mode_q <= LANE_LO;
    else if (force_normal_i || (instr_done_i && !instr_is_arm_i)) mode_q <= LANE_FULL;
  end

  assign mode_o = mode_q;

  // R2
  arm_hi_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_hi_i |=> (mode_o == LANE_HI));
  // R3
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_done_i && !instr_is_arm_i && !arm_hi_i && !arm_lo_i) |=> (mode_o == LANE_FULL));
  // R4
  arm_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_done_i && instr_is_arm_i && !force_normal_i && !arm_hi_i && !arm_lo_i)
      |=> (mode_o == $past(mode_o)));
endmodule

// File: rtl/bl_lane_merge.sv
module bl_lane_merge
  import bl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  lane_mode_e        mode_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] rd_word_o,
  output logic [DATA_W-1:0] wr_word_o
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int PAD_W  = DATA_W - BYTE_W;

  always_comb begin
    unique case (mode_i)
      LANE_HI: begin
        rd_word_o = {{PAD_W{1'b0}}, word_i[DATA_W-1:BYTE_W]};
        wr_word_o = {opnd_i[BYTE_W-1:0], word_i[BYTE_W-1:0]};
      end
      LANE_LO: begin
        rd_word_o = {{PAD_W{1'b0}}, word_i[BYTE_W-1:0]};
        wr_word_o = {word_i[DATA_W-1:BYTE_W], opnd_i[BYTE_W-1:0]};
      end
      default: begin
        rd_word_o = word_i;
        wr_word_o = opnd_i;
      end
    endcase
  end
endmodule

// File: rtl/bl_access_seq.sv
module bl_access_seq
  import bl_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lane_mode_e        eff_mode_i,
  input  logic              op_rd_req_i,
  input  logic              op_wr_req_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [DATA_W-1:0] op_wdata_i,
  output logic [DATA_W-1:0] op_rdata_o,
  output logic              op_done_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  typedef enum logic [1:0] {S_IDLE, S_RDATA, S_MERGE} seq_e;

  seq_e              state_q, state_d;
  lane_mode_e        mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_word, wr_word;
  logic              accept;

  bl_lane_merge #(.DATA_W(DATA_W)) u_merge (
    .mode_i   (mode_q),
    .word_i   (mem_rdata_i),
    .opnd_i   (wdata_q),
    .rd_word_o(rd_word),
    .wr_word_o(wr_word)
  );

  assign accept = (state_q == S_IDLE) && (op_rd_req_i || op_wr_req_i);

  always_comb begin
    state_d     = state_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = addr_q;
    mem_wdata_o = wr_word;
    op_rdata_o  = '0;
    op_done_o   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        mem_addr_o = op_addr_i;
        if (op_rd_req_i) begin
          mem_req_o = 1'b1;
          state_d   = S_RDATA;
        end else if (op_wr_req_i) begin
          mem_req_o = 1'b1;
          if (eff_mode_i == LANE_FULL) begin
            mem_we_o    = 1'b1;
            mem_wdata_o = op_wdata_i;
            op_done_o   = 1'b1;
          end else begin
            state_d = S_MERGE; // read half of read-modify-write
          end
        end
      end
      S_RDATA: begin
        op_rdata_o = rd_word;
        op_done_o  = 1'b1;
        state_d    = S_IDLE;
      end
      S_MERGE: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        op_done_o = 1'b1;
        state_d   = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mode_q  <= LANE_FULL;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        mode_q  <= eff_mode_i;
        addr_q  <= op_addr_i;
        wdata_q <= op_wdata_i;
      end
    end
  end

  assign busy_o = (state_q != S_IDLE);

  // R8
  rmw_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_we_o) |-> $past(mem_req_o && !mem_we_o));
  // R7
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && op_rd_req_i) |=> op_done_o);
  // R10
  full_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !op_rd_req_i && op_wr_req_i && eff_mode_i == LANE_FULL) |=> !busy_o);
endmodule

// File: rtl/byte_lane_ctrl.sv
module byte_lane_ctrl
  import bl_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_hi_i,
  input  logic              arm_lo_i,
  input  logic              instr_done_i,
  input  logic              instr_is_arm_i,
  input  logic              force_normal_i,
  input  logic              op_rd_req_i,
  input  logic              op_wr_req_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [DATA_W-1:0] op_wdata_i,
  output logic [DATA_W-1:0] op_rdata_o,
  output logic              op_done_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              atomic_o
);
  lane_mode_e mode, eff_mode;

  bl_mode_reg u_mode (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .arm_hi_i      (arm_hi_i),
    .arm_lo_i      (arm_lo_i),
    .instr_done_i  (instr_done_i),
    .instr_is_arm_i(instr_is_arm_i),
    .force_normal_i(force_normal_i),
    .mode_o        (mode)
  );

  assign eff_mode = force_normal_i ? LANE_FULL : mode;

  bl_access_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eff_mode_i (eff_mode),
    .op_rd_req_i(op_rd_req_i),
    .op_wr_req_i(op_wr_req_i),
    .op_addr_i  (op_addr_i),
    .op_wdata_i (op_wdata_i),
    .op_rdata_o (op_rdata_o),
    .op_done_o  (op_done_o),
    .busy_o     (busy_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  assign atomic_o = (mode != LANE_FULL);

  // R2
  atomic_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(atomic_o) |-> $past(arm_hi_i || arm_lo_i));
  // R11
  force_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_normal_i && !arm_hi_i && !arm_lo_i) |=> !atomic_o);
endmodule

// File: tb/byte_lane_ctrl_bench.sv
module byte_lane_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm_hi = 0, arm_lo = 0, idone = 0, iarm = 0, force_n = 0;
  logic        rd_req = 0, wr_req = 0;
  logic [10:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, mem_wdata, mem_rdata = '0;
  logic        done, busy, mem_req, mem_we, atomic;
  logic [10:0] mem_addr;
  logic [15:0] mem [0:15];
  int          errors = 0, checks = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  byte_lane_ctrl u_byte_lane_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .arm_hi_i(arm_hi), .arm_lo_i(arm_lo),
    .instr_done_i(idone), .instr_is_arm_i(iarm), .force_normal_i(force_n),
    .op_rd_req_i(rd_req), .op_wr_req_i(wr_req), .op_addr_i(addr), .op_wdata_i(wdata),
    .op_rdata_o(rdata), .op_done_o(done), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .atomic_o(atomic)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[3:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[3:0]];
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic arm(input bit hi);
    @(negedge clk);
    arm_hi = hi; arm_lo = !hi; idone = 1; iarm = 1;
    @(negedge clk);
    arm_hi = 0; arm_lo = 0; idone = 0; iarm = 0;
  endtask

  task automatic finish_instr();
    @(negedge clk); idone = 1; iarm = 0;
    @(negedge clk); idone = 0;
  endtask

  task automatic bus_read(input logic [10:0] a, input bit frc,
                          output logic [15:0] d, output logic dn);
    @(negedge clk); rd_req = 1; addr = a; force_n = frc;
    @(negedge clk); rd_req = 0; force_n = 0;
    d = rdata; dn = done;
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [15:0] v, input bit frc,
                           output logic imm_done, output logic bsy, output logic late_done);
    @(negedge clk); wr_req = 1; addr = a; wdata = v; force_n = frc;
    #1 imm_done = done;
    @(negedge clk); wr_req = 0; force_n = 0;
    bsy = busy; late_done = busy ? done : 1'b0;
    if (bsy) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 atomic", {15'd0, atomic}, 16'd0);
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 mem_req", {15'd0, mem_req}, 16'd0);
  endtask

  task automatic t_full();
    logic [15:0] d; logic dn, i, b, l;
    bus_read(11'd1, 0, d, dn);
    chk("R7 full read data", d, 16'hC3A1);
    chk("R7 done after one cycle", {15'd0, dn}, 16'd1);
    bus_write(11'd2, 16'h5AA5, 0, i, b, l);
    chk("R10 done in request cycle", {15'd0, i}, 16'd1);
    chk("R10 no busy", {15'd0, b}, 16'd0);
    chk("R10 word stored", mem[2], 16'h5AA5);
  endtask

  task automatic t_hi();
    logic [15:0] d; logic dn, i, b, l;
    arm(1);
    chk("R2 atomic when armed hi", {15'd0, atomic}, 16'd1);
    bus_read(11'd3, 0, d, dn);
    chk("R5 high lane read", d, 16'h00A5);
    finish_instr();
    chk("R3 atomic cleared", {15'd0, atomic}, 16'd0);
    bus_read(11'd3, 0, d, dn);
    chk("R3 next read full word", d, 16'hA55C);
    arm(1);
    bus_write(11'd3, 16'h1234, 0, i, b, l);
    chk("R8 busy during rmw", {15'd0, b}, 16'd1);
    chk("R8 done on write cycle", {15'd0, l}, 16'd1);
    chk("R8 high lane merged", mem[3], 16'h345C);
    finish_instr();
  endtask

  task automatic t_lo();
    logic [15:0] d; logic dn, i, b, l;
    arm(0);
    chk("R2 atomic when armed lo", {15'd0, atomic}, 16'd1);
    bus_read(11'd5, 0, d, dn);
    chk("R6 low lane read", d, 16'h00EF);
    finish_instr();
    arm(0);
    bus_write(11'd5, 16'h9977, 0, i, b, l);
    chk("R9 low lane merged", mem[5], 16'hBE77);
    finish_instr();
  endtask

  task automatic t_force();
    logic [15:0] d; logic dn, i, b, l;
    mem[3] = 16'hA55C;
    arm(1);
    bus_read(11'd3, 1, d, dn);
    chk("R11 forced read full", d, 16'hA55C);
    chk("R11 mode cleared", {15'd0, atomic}, 16'd0);
    arm(0);
    bus_write(11'd6, 16'hF00D, 1, i, b, l);
    chk("R11 forced write no busy", {15'd0, b}, 16'd0);
    chk("R11 forced write full", mem[6], 16'hF00D);
  endtask

  task automatic t_rearm();
    logic [15:0] d; logic dn;
    arm(1);
    arm(0);
    @(negedge clk); idone = 1; iarm = 1;
    @(negedge clk); idone = 0; iarm = 0;
    chk("R4 armed kept", {15'd0, atomic}, 16'd1);
    bus_read(11'd7, 0, d, dn);
    chk("R4 later arm wins", d, 16'h0034);
    finish_instr();
  endtask

  initial begin
    for (int k = 0; k < 16; k++) mem[k] = 16'h0000;
    mem[1] = 16'hC3A1; mem[3] = 16'hA55C; mem[5] = 16'hBEEF; mem[7] = 16'h1234;
    #20 t_reset();
    @(negedge clk); rst_n = 1;
    t_reset();
    t_full();
    t_hi();
    t_lo();
    t_force();
    t_rearm();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule